// File: doc/BRIEF.md
# Three-Stage Multiply-Add Stream Pipeline

This block evaluates `a * b + c` on a continuous stream of unsigned operands and returns one result on every clock once it is full. The work is split over three register-separated segments. The first registers the two multiplicands. The second registers their product, and on that same edge it registers the addend. The third registers the sum. Three operand sets can therefore be in flight at once, one in each segment.

The addend has a timing rule of its own. It is not sampled together with its multiplicands. It is sampled one clock later, on the edge that loads the product, so the adder always sees a matching pair. A source that feeds the block holds `a_in`/`b_in` with `in_valid` for one cycle and drives the matching `c_in` in the cycle after that. A valid flag moves down the segments with each operand set, and `out_valid` marks the cycles in which `result` belongs to a real input. When the input stops, the clock must keep running for three more edges so that the last result can leave the output register. There is no stall path: a result that is presented is gone one clock later.

Top module: `mac_stream_pipe`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it returns high, `out_valid` is 0. A reset also discards every operand set that was in flight when it was applied, so none of them ever produces a result.
- R2: A result marked valid equals `a*b + c` as an unsigned 33-bit value. Here `a` and `b` are the values on `a_in` and `b_in` at the clock edge where `in_valid` was 1, and `c` is the value on `c_in` at the following clock edge.
- R3: For operands sampled at clock edge k, `out_valid` is 1 and `result` holds their value in the cycle that follows edge k+2. This is three edges counting the capture edge.
- R4: When `in_valid` is high on consecutive edges, the results come out on consecutive cycles and in input order, one per clock.
- R5: `out_valid` is 1 only in cycles that carry the result of a real operand set. A gap in `in_valid` gives a gap of the same length at the output.
- R6: The full operand range is exact: all-ones operands (0xFFFF, 0xFFFF, 0xFFFF) give 0x0FFFF0000, and zero operands give 0.
- R7: After `in_valid` goes low, the operand sets already in flight still come out over the next clocks with no further input, and then `out_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for every segment register |
| rst_n | input | 1 | Synchronous reset, active low; clears the valid flags |
| in_valid | input | 1 | High when `a_in`/`b_in` carry a new operand set |
| a_in | input | 16 | Multiplicand, unsigned |
| b_in | input | 16 | Multiplier, unsigned |
| c_in | input | 16 | Addend, unsigned; driven one cycle after its multiplicands |
| out_valid | output | 1 | High when `result` belongs to a real operand set |
| result | output | 33 | Registered `a*b + c` |

## Verification
The bound checker follows every cycle against the ports. It checks that a valid input shows up as a valid output exactly three edges later, and that no valid output appears without a matching input. It checks the arithmetic value against the operands sampled at the two capture edges, that back-to-back inputs keep the output busy on consecutive cycles, and that reset leaves the output idle. Some behaviours only the bench scenarios can show. These are the discarding of operand sets caught in flight by a mid-stream reset, the exact extreme values, the ordering of a long burst, and the drain, where the queue of expected results must empty completely after the input stops.

// File: rtl/mac_pkg.sv
// Package: mac_pkg
// Shared widths and helpers for the multiply-add stream pipeline.
// Assumes operands are unsigned. The product is twice the operand width,
// and the result carries one extra bit so the final add cannot wrap.
package mac_pkg;

    localparam int unsigned MAC_OPND_W_DEF = 16;
    localparam int unsigned MAC_LATENCY    = 3;

    // Width of the full product of two operands of width w.
    function automatic int unsigned prod_width(input int unsigned w);
        return 2 * w;
    endfunction

    // Width of product plus addend, with headroom for the carry.
    function automatic int unsigned res_width(input int unsigned w);
        return 2 * w + 1;
    endfunction

endpackage

// File: rtl/mac_capture_stage.sv
// Module: mac_capture_stage
// Segment one: registers the two multiplicands and their valid flag.
// Assumes: the data registers load on every edge whether or not valid is
// high; only the valid flag is cleared by the synchronous active-low reset.
module mac_capture_stage #(
    parameter int unsigned OPND_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic [OPND_W-1:0] a_i,
    input  logic [OPND_W-1:0] b_i,
    output logic              vld_o,
    output logic [OPND_W-1:0] a_o,
    output logic [OPND_W-1:0] b_o
);

    // Valid flag: cleared by reset, otherwise follows the input strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_o <= 1'b0;
        else        vld_o <= vld_i;
    end

    // Operand registers: free-running load, no reset needed.
    always_ff @(posedge clk) begin
        a_o <= a_i;
        b_o <= b_i;
    end

endmodule

// File: rtl/mac_product_stage.sv
// Module: mac_product_stage
// Segment two: multiplies the registered operands and, on the same edge,
// registers the addend that arrives one cycle after its multiplicands.
// Assumes: c_i belongs to the operand set now held in segment one.
module mac_product_stage #(
    parameter int unsigned OPND_W = 16,
    localparam int unsigned PROD_W = mac_pkg::prod_width(OPND_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic [OPND_W-1:0] a_i,
    input  logic [OPND_W-1:0] b_i,
    input  logic [OPND_W-1:0] c_i,
    output logic              vld_o,
    output logic [PROD_W-1:0] prod_o,
    output logic [OPND_W-1:0] c_o
);

    logic [PROD_W-1:0] prod_d;

    // Full-width unsigned product of the segment-one registers.
    always_comb prod_d = PROD_W'(a_i) * PROD_W'(b_i);

    // Valid flag: cleared by reset, otherwise passed on from segment one.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_o <= 1'b0;
        else        vld_o <= vld_i;
    end

    // Product and addend registers load together on every edge.
    always_ff @(posedge clk) begin
        prod_o <= prod_d;
        c_o    <= c_i;
    end

endmodule

// File: rtl/mac_sum_stage.sv
// Module: mac_sum_stage
// Segment three: adds the addend to the product and registers the result.
// Assumes the result width is one bit wider than the product.
module mac_sum_stage #(
    parameter int unsigned OPND_W = 16,
    localparam int unsigned PROD_W = mac_pkg::prod_width(OPND_W),
    localparam int unsigned RES_W  = mac_pkg::res_width(OPND_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vld_i,
    input  logic [PROD_W-1:0] prod_i,
    input  logic [OPND_W-1:0] c_i,
    output logic              vld_o,
    output logic [RES_W-1:0]  sum_o
);

    logic [RES_W-1:0] sum_d;

    // Zero-extended add, so the carry out of the product width is kept.
    always_comb sum_d = RES_W'(prod_i) + RES_W'(c_i);

    // Valid flag: cleared by reset, otherwise passed on from segment two.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_o <= 1'b0;
        else        vld_o <= vld_i;
    end

    // Output register loads the sum on every edge.
    always_ff @(posedge clk) begin
        sum_o <= sum_d;
    end

endmodule

// File: rtl/mac_stream_pipe.sv
// Module: mac_stream_pipe (top)
// Three-segment unsigned multiply-add pipeline: result = a*b + c.
// Assumes: c_in is driven one cycle after the a_in/b_in it belongs to.
// There is no stall input; latency is three edges and throughput is one
// result per clock. After input stops, the clock must keep running.
module mac_stream_pipe #(
    parameter int unsigned OPND_W = mac_pkg::MAC_OPND_W_DEF,
    localparam int unsigned PROD_W = mac_pkg::prod_width(OPND_W),
    localparam int unsigned RES_W  = mac_pkg::res_width(OPND_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OPND_W-1:0] a_in,
    input  logic [OPND_W-1:0] b_in,
    input  logic [OPND_W-1:0] c_in,
    output logic              out_valid,
    output logic [RES_W-1:0]  result
);

    logic              s1_vld;
    logic [OPND_W-1:0] s1_a;
    logic [OPND_W-1:0] s1_b;
    logic              s2_vld;
    logic [PROD_W-1:0] s2_prod;
    logic [OPND_W-1:0] s2_c;

    mac_capture_stage #(.OPND_W(OPND_W)) u_seg1 (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_i (in_valid),
        .a_i   (a_in),
        .b_i   (b_in),
        .vld_o (s1_vld),
        .a_o   (s1_a),
        .b_o   (s1_b)
    );

    mac_product_stage #(.OPND_W(OPND_W)) u_seg2 (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (s1_vld),
        .a_i    (s1_a),
        .b_i    (s1_b),
        .c_i    (c_in),
        .vld_o  (s2_vld),
        .prod_o (s2_prod),
        .c_o    (s2_c)
    );

    mac_sum_stage #(.OPND_W(OPND_W)) u_seg3 (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_i  (s2_vld),
        .prod_i (s2_prod),
        .c_i    (s2_c),
        .vld_o  (out_valid),
        .sum_o  (result)
    );

endmodule

// File: rtl/mac_stream_checker.sv
// Module: mac_stream_checker
// Port-level temporal checks for mac_stream_pipe, attached by bind.
// A saturating counter of edges since reset guards every $past look-back.
module mac_stream_checker #(
    parameter int unsigned OPND_W = 16,
    localparam int unsigned RES_W = mac_pkg::res_width(OPND_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [OPND_W-1:0] a_in,
    input logic [OPND_W-1:0] b_in,
    input logic [OPND_W-1:0] c_in,
    input logic              out_valid,
    input logic [RES_W-1:0]  result
);

    logic [1:0] since_rst = 2'd0;
    logic       rst_hold  = 1'b0;

    // Count edges since reset release, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_rst <= 2'd0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // The output stays idle in the cycle after a reset edge.
    always_ff @(posedge clk) begin
        if (rst_hold) p_idle_after_reset_r1: assert (!out_valid);
        rst_hold <= !rst_n;
    end

    p_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && out_valid) |->
        result == (RES_W'($past(a_in, 3)) * RES_W'($past(b_in, 3))
                   + RES_W'($past(c_in, 2))));

    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && $past(in_valid, 3)) |-> out_valid);

    p_no_phantom_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && out_valid) |-> $past(in_valid, 3));

    p_back_to_back_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && $past(in_valid, 3) && $past(in_valid, 2))
        |=> (out_valid && $past(out_valid)));

endmodule

bind mac_stream_pipe mac_stream_checker #(.OPND_W(OPND_W)) u_mac_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .a_in      (a_in),
    .b_in      (b_in),
    .c_in      (c_in),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/tb_mac_stream_pipe.sv
// Scoreboard bench for mac_stream_pipe. The driver pushes expected results
// and their due cycle; the monitor pops and compares at each falling edge.
module tb_mac_stream_pipe;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned W  = 16;
    localparam int unsigned RW = 2 * W + 1;

    typedef struct {
        logic [RW-1:0] val;
        int            due;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [W-1:0]  a_in = '0, b_in = '0, c_in = '0;
    logic          out_valid;
    logic [RW-1:0] result;

    exp_t          sb[$];
    int            cyc = 0;
    int            n_chk = 0;
    int            n_fail = 0;
    int            n_seen = 0;
    logic [W-1:0]  c_next = '0;
    logic          done = 1'b0;

    mac_stream_pipe #(.OPND_W(W)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_in(a_in), .b_in(b_in), .c_in(c_in),
        .out_valid(out_valid), .result(result)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [RW-1:0] act,
                         input logic [RW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Drive one slot: a/b now, the previous slot's c now, remember this c.
    task automatic step(input bit v, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [W-1:0] c, input string tag);
        @(negedge clk);
        in_valid = v;
        a_in     = a;
        b_in     = b;
        c_in     = c_next;
        c_next   = c;
        if (v && rst_n) sb.push_back('{val: RW'(a) * RW'(b) + RW'(c), due: cyc + 3, tag: tag});
    endtask

    // Monitor: compares outputs with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                n_seen++;
                if (sb.size() == 0) begin
                    check(1'b0, "R5 unexpected out_valid", RW'(1), RW'(0));
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(e.due == cyc, "R3 latency", RW'(cyc), RW'(e.due));
                    check(result == e.val, e.tag, result, e.val);
                end
            end else if (sb.size() != 0 && sb[0].due <= cyc) begin
                check(1'b0, "R3/R4 missing result", RW'(0), RW'(1));
                void'(sb.pop_front());
            end
        end
    end

    task automatic finish_run;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state, with junk valid input during reset.
        repeat (3) step(1'b1, 16'h1234, 16'h5678, 16'h9abc, "R1");
        check(out_valid == 1'b0, "R1 out_valid in reset", RW'(out_valid), RW'(0));
        @(negedge clk); rst_n = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after reset", RW'(out_valid), RW'(0));

        // R2: single set, then drain.
        step(1'b1, 16'd3, 16'd7, 16'd5, "R2 single 3*7+5");
        repeat (5) step(1'b0, '0, '0, 16'hdead, "idle");

        // R6: extremes.
        step(1'b1, 16'hffff, 16'hffff, 16'hffff, "R6 all ones");
        step(1'b1, 16'h0000, 16'h0000, 16'h0000, "R6 zeros");
        step(1'b1, 16'hffff, 16'h0001, 16'hffff, "R6 carry");
        repeat (5) step(1'b0, '0, '0, 16'h0bad, "idle");

        // R4: back-to-back burst in order.
        for (int i = 0; i < 12; i++)
            step(1'b1, W'($urandom), W'($urandom), W'($urandom), "R4 burst");
        // R7: stop input, the in-flight sets must still emerge.
        repeat (6) step(1'b0, '0, '0, 16'hbeef, "idle");
        check(sb.size() == 0, "R7 drain queue empty", RW'(sb.size()), RW'(0));

        // R5: gapped pattern, gaps must reappear at the output.
        for (int i = 0; i < 16; i++)
            step((i % 3) != 1, W'($urandom), W'($urandom), W'($urandom), "R5 gapped");
        repeat (6) step(1'b0, '0, '0, '0, "idle");

        // R1: reset with sets in flight discards them.
        step(1'b1, 16'd11, 16'd11, 16'd11, "R1 flushed");
        step(1'b1, 16'd12, 16'd12, 16'd12, "R1 flushed");
        @(negedge clk); rst_n = 1'b0; in_valid = 1'b0;
        sb.delete();
        @(negedge clk); rst_n = 1'b1;
        begin
            int hits = 0;
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                if (out_valid) hits++;
            end
            check(hits == 0, "R1 in-flight discarded", RW'(hits), RW'(0));
        end

        // R7: final single set followed by drain.
        step(1'b1, 16'd1000, 16'd999, 16'd1, "R7 last set");
        repeat (5) step(1'b0, '0, '0, '0, "idle");
        check(sb.size() == 0, "R7 final drain", RW'(sb.size()), RW'(0));
        check(n_seen == 1 + 3 + 12 + 11 + 1, "R5 result count", RW'(n_seen), RW'(28));
        finish_run();
    end

endmodule